// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and date as seven byte-wide BCD registers: seconds, minutes, hours, day of week, date, month and year. A timebase strobe is counted down by an internal sub-second divider. Each time the divider completes a full second, the time advances by one second. The advance ripples through minutes, hours, day of week, date, month and year within the same clock cycle.

The hour register holds either a 24-hour value or a 12-hour value with an AM/PM flag, and a format bit inside the register selects which. The date wraps at the real length of each month. February gets a 29th day in every year divisible by four. A century flag in the month register inverts each time the year wraps from 99 to 00.

A host loads any register through a single-cycle write port and sees all seven registers in parallel at all times. Every write also restarts the sub-second divider, so a freshly loaded time holds for one full second before its first advance.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the outputs read seconds 0x00, minutes 0x00, hours 0x00 (bit 6 = 0, 24-hour format), day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Seconds and minutes count in BCD. The low digit rolls 9 to 0 and carries into the tens digit. At 0x59 the register returns to 0x00, and a seconds wrap advances minutes by one.
- R3: With hour bit 6 = 0 (24-hour format), bits 5:0 count BCD 0x00 to 0x23, where bit 5 is the tens digit for 20 to 23. The step from 0x23 goes to 0x00 and advances the date.
- R4: With hour bit 6 = 1 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01 to 12. The sequence is 12 AM, 1 AM to 11 AM, 12 PM, 1 PM to 11 PM, then 12 AM. The step 11 to 12 inverts bit 5, and only the 11 PM to 12 AM step advances the date.
- R5: Day of week (bits 2:0) advances by one on every date advance and goes from 7 back to 1.
- R6: The date runs from 0x01 up to the month's last day and then returns to 0x01 while the month advances. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months except February.
- R7: February ends on 0x29 when the BCD year is divisible by four (00, 04 … 96, including 00), and on 0x28 otherwise.
- R8: Month (bits 4:0) advances from 0x12 to 0x01 and advances the year. The year goes from 0x99 to 0x00, and in that same step month bit 7 (century flag) inverts.
- R9: A write at address 0 to 6 (seconds, minutes, hours, day of week, date, month, year) loads the data masked so that unused bits read zero. The masks are: seconds/minutes/hours 0x7F, day of week 0x07, date 0x3F, month 0x9F, year 0xFF. The value is visible the cycle after the write.
- R10: Any write restarts the sub-second phase. The next advance happens on the TICK_DIV-th strobe after the write, not earlier.
- R11: A one-second advance that falls in the same cycle as a write is discarded. Only the written register changes in that cycle.
- R12: With no intervening write, one second elapses every TICK_DIV timebase strobes. Without strobes the registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_stb_i | input | 1 | Timebase strobe, one cycle per timebase period |
| wr_en_i | input | 1 | Host write enable |
| wr_addr_i | input | 3 | Register select: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with format bit 6 and PM/tens bit 5 |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month BCD with century flag in bit 7 |
| year_o | output | 8 | Year, BCD |

## Verification
All state is visible at the ports, so a faulty carry or wrap term shows up in the cycle right after the tick that uses it. A wrong month length, leap decision or hour sequence shows as a bad date or hour on that first edge. A divider phase that is off by even one strobe shifts the observed second by one strobe after a write. A write that fails to suppress a coincident tick leaves an unwritten register advanced in the next cycle. Preloading each register just before its rollover lets every boundary be exercised with a single tick.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC   = 3'd0,
    A_MIN   = 3'd1,
    A_HOUR  = 3'd2,
    A_DOW   = 3'd3,
    A_DATE  = 3'd4,
    A_MONTH = 3'd5,
    A_YEAR  = 3'd6
  } cal_addr_e;

  localparam logic [BYTE_W-1:0] MSK_SEC   = 8'h7F;
  localparam logic [BYTE_W-1:0] MSK_MIN   = 8'h7F;
  localparam logic [BYTE_W-1:0] MSK_HOUR  = 8'h7F;
  localparam logic [BYTE_W-1:0] MSK_DOW   = 8'h07;
  localparam logic [BYTE_W-1:0] MSK_DATE  = 8'h3F;
  localparam logic [BYTE_W-1:0] MSK_MONTH = 8'h9F;
  localparam logic [BYTE_W-1:0] MSK_YEAR  = 8'hFF;

  // two-digit BCD increment; no wrap handling
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // BCD year divisible by four: even tens with 0/4/8, odd tens with 2/6
  function automatic logic bcd_leap(input logic [BYTE_W-1:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [BYTE_W-1:0] month_last(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic clr_i,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_direct
      assign tick_o = stb_i;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      always_comb begin
        cnt_en = clr_i | stb_i;
        if (clr_i)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign tick_o = stb_i && (cnt_q == LAST);

      AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !tick_o || (DIV == 1)) else $error("phase not restarted"); // R10
    end
  endgenerate

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic              day_o
);

  logic [BYTE_W-1:0] sec_q, sec_d, min_q, min_d, hour_q, hour_d;
  logic [BYTE_W-1:0] inc12;
  logic              min_step, hour_step, time_en;

  always_comb begin
    min_step  = adv_i && (sec_q == 8'h59);
    hour_step = min_step && (min_q == 8'h59);
    time_en   = wr_en_i | adv_i;
    sec_d     = sec_q;
    min_d     = min_q;
    hour_d    = hour_q;
    day_o     = 1'b0;
    inc12     = bcd_inc({3'b000, hour_q[4:0]});
    if (wr_en_i) begin
      case (cal_addr_e'(wr_addr_i))
        A_SEC:   sec_d  = wr_data_i & MSK_SEC;
        A_MIN:   min_d  = wr_data_i & MSK_MIN;
        A_HOUR:  hour_d = wr_data_i & MSK_HOUR;
        default: ;
      endcase
    end else begin
      if (adv_i)    sec_d = (sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q);
      if (min_step) min_d = (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (hour_step) begin
        if (!hour_q[6]) begin
          if (hour_q[5:0] == 6'h23) begin
            hour_d = 8'h00;
            day_o  = 1'b1;
          end else begin
            hour_d = bcd_inc({2'b00, hour_q[5:0]});
          end
        end else begin
          if (hour_q[4:0] == 5'h11) begin
            hour_d = {2'b01, ~hour_q[5], 5'h12};
            day_o  = hour_q[5];
          end else if (hour_q[4:0] == 5'h12) begin
            hour_d = {2'b01, hour_q[5], 5'h01};
          end else begin
            hour_d = {2'b01, hour_q[5], inc12[4:0]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else if (time_en) begin
      sec_q  <= sec_d;
      min_q  <= min_d;
      hour_q <= hour_d;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && sec_q == 8'h59) |=> (sec_q == 8'h00)) else $error("seconds wrap"); // R2
  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_step && hour_q[6] && hour_q[4:0] == 5'h11) |=> (hour_q[5] != $past(hour_q[5])))
    else $error("pm flip"); // R4
  AST_HOUR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hour_q[7] == 1'b0) else $error("hour bit 7 set"); // R9

endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] dow_o,
  output logic [BYTE_W-1:0] date_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] year_o
);

  logic [BYTE_W-1:0] dow_q, dow_d, date_q, date_d, month_q, month_d, year_q, year_d;
  logic [BYTE_W-1:0] last_day;
  logic              mon_step, year_step, date_en;

  always_comb begin
    last_day  = month_last(month_q[4:0], bcd_leap(year_q));
    mon_step  = day_i && (date_q == last_day);
    year_step = mon_step && (month_q[4:0] == 5'h12);
    date_en   = wr_en_i | day_i;
    dow_d     = dow_q;
    date_d    = date_q;
    month_d   = month_q;
    year_d    = year_q;
    if (wr_en_i) begin
      case (cal_addr_e'(wr_addr_i))
        A_DOW:   dow_d   = wr_data_i & MSK_DOW;
        A_DATE:  date_d  = wr_data_i & MSK_DATE;
        A_MONTH: month_d = wr_data_i & MSK_MONTH;
        A_YEAR:  year_d  = wr_data_i & MSK_YEAR;
        default: ;
      endcase
    end else begin
      if (day_i) begin
        dow_d  = (dow_q[2:0] == 3'd7) ? 8'h01 : {5'b0, dow_q[2:0] + 3'd1};
        date_d = mon_step ? 8'h01 : bcd_inc(date_q);
      end
      if (mon_step) begin
        if (year_step)
          month_d = {month_q[7] ^ (year_q == 8'h99), 7'h01};
        else
          month_d = {month_q[7], 2'b00, bcd_inc({3'b000, month_q[4:0]})[4:0]};
      end
      if (year_step) year_d = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q   <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else if (date_en) begin
      dow_q   <= dow_d;
      date_q  <= date_d;
      month_q <= month_d;
      year_q  <= year_d;
    end
  end

  assign dow_o   = dow_q;
  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_i && dow_q == 8'h07) |=> (dow_q == 8'h01)) else $error("dow wrap"); // R5
  AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (year_step && year_q == 8'h99) |=> (month_q[7] != $past(month_q[7])))
    else $error("century flag"); // R8
  AST_LEAP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (day_i && month_q == 8'h02 && date_q == 8'h28 && bcd_leap(year_q)) |=> (date_q == 8'h29))
    else $error("leap day skipped"); // R7

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_stb_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic [BYTE_W-1:0] dow_o,
  output logic [BYTE_W-1:0] date_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] year_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick_raw, adv, day_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cal_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .stb_i  (tb_stb_i),
    .clr_i  (wr_en_i),
    .tick_o (tick_raw)
  );

  // host write wins over a coincident second
  assign adv = tick_raw & ~wr_en_i;

  cal_time_chain u_time (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .adv_i     (adv),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour_o),
    .day_o     (day_step)
  );

  cal_date_chain u_date (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .day_i     (day_step),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .dow_o     (dow_o),
    .date_o    (date_o),
    .month_o   (month_o),
    .year_o    (year_o)
  );

  AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en_i && wr_addr_i != 3'd0) |=> (sec_o == $past(sec_o))) else $error("tick not dropped"); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_en_i && !tb_stb_i) |=> $stable(sec_o)) else $error("advance without strobe"); // R12

endmodule

// File: tb/bcd_calendar_core_tb.sv
`timescale 1ns/1ps
module bcd_calendar_core_tb;

  localparam int DIV = 4;
  localparam int NV  = 28;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tb_stb, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] sec, mn, hr, dow, dt, mon, yr;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar_core #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tb_stb_i(tb_stb), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(mn), .hour_o(hr), .dow_o(dow),
    .date_o(dt), .month_o(mon), .year_o(yr)
  );

  // byte order {year, month, date, dow, hour, min, sec}
  localparam logic [55:0] VIN [NV] = '{
    56'h23_01_15_03_10_30_12, 56'h23_01_15_03_10_30_09, 56'h23_01_15_03_10_30_59,
    56'h23_01_15_03_09_59_59, 56'h23_01_15_03_19_59_59, 56'h23_01_15_03_23_59_59,
    56'h23_01_15_07_23_59_59, 56'h23_01_31_02_23_59_59, 56'h23_04_30_02_23_59_59,
    56'h23_09_30_02_23_59_59, 56'h23_11_30_02_23_59_59, 56'h23_10_30_02_23_59_59,
    56'h23_02_28_02_23_59_59, 56'h24_02_28_02_23_59_59, 56'h24_02_29_02_23_59_59,
    56'h00_02_28_02_23_59_59, 56'h12_02_28_02_23_59_59, 56'h10_02_28_02_23_59_59,
    56'h23_12_31_02_23_59_59, 56'h19_12_31_02_23_59_59, 56'h99_12_31_02_23_59_59,
    56'h99_92_31_02_23_59_59, 56'h23_01_15_03_51_59_59, 56'h23_01_15_03_72_59_59,
    56'h23_01_15_03_71_59_59, 56'h23_01_15_03_52_59_59, 56'h23_01_15_03_49_59_59,
    56'h23_06_30_02_23_59_59
  };
  localparam logic [55:0] VEXP [NV] = '{
    56'h23_01_15_03_10_30_13, 56'h23_01_15_03_10_30_10, 56'h23_01_15_03_10_31_00,
    56'h23_01_15_03_10_00_00, 56'h23_01_15_03_20_00_00, 56'h23_01_16_04_00_00_00,
    56'h23_01_16_01_00_00_00, 56'h23_02_01_03_00_00_00, 56'h23_05_01_03_00_00_00,
    56'h23_10_01_03_00_00_00, 56'h23_12_01_03_00_00_00, 56'h23_10_31_03_00_00_00,
    56'h23_03_01_03_00_00_00, 56'h24_02_29_03_00_00_00, 56'h24_03_01_03_00_00_00,
    56'h00_02_29_03_00_00_00, 56'h12_02_29_03_00_00_00, 56'h10_03_01_03_00_00_00,
    56'h24_01_01_03_00_00_00, 56'h20_01_01_03_00_00_00, 56'h00_81_01_03_00_00_00,
    56'h00_01_01_03_00_00_00, 56'h23_01_15_03_72_00_00, 56'h23_01_15_03_61_00_00,
    56'h23_01_16_04_52_00_00, 56'h23_01_15_03_41_00_00, 56'h23_01_15_03_50_00_00,
    56'h23_07_01_03_00_00_00
  };
  // R2 x3, R3 x3, R5, R6 x5, R7 x6, R8 x4, R4 x5, R6
  localparam int VREQ [NV] = '{2, 2, 2, 3, 3, 3, 5, 6, 6, 6, 6, 6, 7, 7, 7, 7, 7, 7,
                               8, 8, 8, 8, 4, 4, 4, 4, 4, 6};

  task automatic chk(input int req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic collide(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; tb_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; tb_stb = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      tb_stb = 1'b1;
      @(negedge clk);
    end
    tb_stb = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tb_stb = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(1, "reset sec", sec, 8'h00);
    chk(1, "reset min", mn, 8'h00);
    chk(1, "reset hour (24h)", hr, 8'h00);
    chk(1, "reset dow", dow, 8'h01);
    chk(1, "reset date", dt, 8'h01);
    chk(1, "reset month", mon, 8'h01);
    chk(1, "reset year", yr, 8'h00);

    // R12 one second per DIV strobes, hold without strobes
    strobes(DIV - 1);
    chk(12, "before full count", sec, 8'h00);
    strobes(1);
    chk(12, "after full count", sec, 8'h01);
    repeat (10) @(negedge clk);
    chk(12, "idle hold", sec, 8'h01);

    // vector table: preload, one second, compare all registers
    for (int v = 0; v < NV; v++) begin
      for (int b = 0; b < 7; b++) wr(3'(b), VIN[v][b*8 +: 8]);
      strobes(DIV);
      chk(VREQ[v], $sformatf("vector %0d", v), {8'h00, yr, mon, dt, dow, hr, mn, sec}, {8'h00, VEXP[v]});
    end

    // R9 write masking
    for (int b = 0; b < 7; b++) wr(3'(b), 8'hFF);
    chk(9, "sec mask", sec, 8'h7F);
    chk(9, "min mask", mn, 8'h7F);
    chk(9, "hour mask", hr, 8'h7F);
    chk(9, "dow mask", dow, 8'h07);
    chk(9, "date mask", dt, 8'h3F);
    chk(9, "month mask", mon, 8'h9F);
    chk(9, "year mask", yr, 8'hFF);

    // R10 write restarts the sub-second phase
    wr(3'd0, 8'h10);
    strobes(DIV - 1);
    chk(10, "no early tick after write", sec, 8'h10);
    strobes(1);
    chk(10, "tick after full phase", sec, 8'h11);
    strobes(2);
    wr(3'd1, 8'h05);
    strobes(DIV - 1);
    chk(10, "mid-phase write restarts", sec, 8'h11);
    chk(10, "minute loaded", mn, 8'h05);
    strobes(1);
    chk(10, "tick after restarted phase", sec, 8'h12);

    // R11 coincident tick dropped
    strobes(DIV - 1);
    collide(3'd1, 8'h20);
    chk(11, "sec not advanced on collision", sec, 8'h12);
    chk(11, "min written on collision", mn, 8'h20);
    strobes(DIV - 1);
    chk(11, "no tick before new phase", sec, 8'h12);
    strobes(1);
    chk(11, "tick after collision", sec, 8'h13);
    strobes(DIV - 1);
    collide(3'd0, 8'h30);
    chk(11, "written sec not advanced", sec, 8'h30);
    strobes(DIV - 1);
    chk(11, "written sec holds", sec, 8'h30);
    strobes(1);
    chk(11, "written sec advances later", sec, 8'h31);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule